// File: doc/BRIEF.md
# Write-Through Store Buffer

This block sits between a write-through cache and a slow DRAM. Each processor store goes into the cache. In the same cycle it is offered to this buffer as an address, data and byte-enable entry. The buffer holds up to four entries. A memory-side drain presents them to DRAM strictly oldest first, one write at a time. After each DRAM write is accepted, the drain waits out a programmable write cycle time before it offers the next entry.

The store side is a valid/ready stream. A store is taken on any cycle where `st_valid` and `st_ready` are both high. When the buffer is full, `st_ready` drops and the processor must hold its store and stall. There is one exception: if DRAM accepts the head entry in that same cycle, the store is taken, so a full buffer can swap one entry out and one in. The DRAM side is also a valid/ready stream. While `dram_valid` is high and `dram_ready` is low, the offered entry stays unchanged. A plain `empty` flag lets fence logic wait until every buffered store has fully left the block.

Top module: `wt_store_buf`

## Requirements
- R1: After reset, `empty` is 1, `dram_valid` is 0 and `st_ready` is 1.
- R2: Entries leave on the DRAM port in exactly the order they were accepted. Address, data and byte enables are unchanged. The port packs them as {addr[31:0], data[31:0], be[3:0]}.
- R3: With 4 entries held and no DRAM acceptance in the cycle, `st_ready` is 0. A store offered then is not taken and is not lost while it is held.
- R4: With 4 entries held and a DRAM acceptance in the cycle, `st_ready` is 1. A store then offered is taken and the occupancy stays at 4.
- R5: After a DRAM acceptance, `dram_valid` stays 0 for the next N-1 cycles. N is the value of `dram_wr_cycles` in the accepting cycle, and N=0 behaves as N=1. So back-to-back writes are possible only with N of 0 or 1.
- R6: `dram_valid` is 1 whenever at least one entry is held and no DRAM write cycle is still running.
- R7: `empty` is 1 exactly when no entry is held and no DRAM write cycle is still running.
- R8: While `dram_valid` is 1 and `dram_ready` is 0, `dram_valid` and the offered entry stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Processor store offered |
| st_ready | output | 1 | Store accepted this cycle if st_valid is also high |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| dram_wr_cycles | input | 8 | DRAM write cycle time in clocks (0 treated as 1) |
| dram_valid | output | 1 | Head entry offered to DRAM |
| dram_ready | input | 1 | DRAM accepts the offered entry |
| dram_addr | output | 32 | Offered write address |
| dram_data | output | 32 | Offered write data |
| dram_be | output | 4 | Offered byte enables |
| empty | output | 1 | No entry held and no DRAM write running |

## Verification
`st_ready`, `dram_valid` and `empty` all come from registered state. `st_ready` also depends on `dram_ready` in the same cycle. So every one of them is due in the cycle its inputs are applied. A store accepted at one edge can appear on the DRAM port from the next cycle on. After an acceptance, the next offer is due exactly N cycles later. The bench drives inputs at the falling edge and samples outputs one nanosecond later. It then advances a cycle-accurate queue model by one rising edge, so each expected value is compared in the very cycle it is due.

// File: rtl/wtsb_pkg.sv
package wtsb_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [BE_W-1:0]   be;
  } st_entry_t;
endpackage

// File: rtl/wtsb_fifo.sv
module wtsb_fifo
  import wtsb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  st_entry_t        wr_ent,
  output st_entry_t        rd_ent,
  output logic             full,
  output logic             is_empty,
  output logic [OCC_W-1:0] occ
);
  st_entry_t        slots [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [OCC_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push && wr_ptr == PW'(gi)) slots[gi] <= wr_ent;
      end
    end
  endgenerate

  assign rd_ent   = slots[rd_ptr];
  assign full     = (count == OCC_W'(DEPTH));
  assign is_empty = (count == '0);
  assign occ      = count;
endmodule

// File: rtl/wtsb_drain.sv
module wtsb_drain #(
  parameter int CYC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             have_entry,
  input  logic             dram_ready,
  input  logic [CYC_W-1:0] cycles,
  output logic             dram_valid,
  output logic             pop,
  output logic             in_flight
);
  logic [CYC_W-1:0] gap;

  assign in_flight  = (gap != '0);
  assign dram_valid = have_entry && !in_flight;
  assign pop        = dram_valid && dram_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap <= '0;
    end else if (pop) begin
      gap <= (cycles == '0) ? '0 : cycles - 1'b1;
    end else if (in_flight) begin
      gap <= gap - 1'b1;
    end
  end
endmodule

// File: rtl/wt_store_buf.sv
module wt_store_buf
  import wtsb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CYC_W = 8,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [BE_W-1:0]   st_be,
  input  logic [CYC_W-1:0]  dram_wr_cycles,
  output logic              dram_valid,
  input  logic              dram_ready,
  output logic [ADDR_W-1:0] dram_addr,
  output logic [DATA_W-1:0] dram_data,
  output logic [BE_W-1:0]   dram_be,
  output logic              empty
);
  st_entry_t        in_ent, head;
  logic             full, fifo_empty, push, pop, in_flight;
  logic [OCC_W-1:0] occ;

  assign in_ent = '{addr: st_addr, data: st_data, be: st_be};

  wtsb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wr_ent(in_ent), .rd_ent(head), .full(full),
    .is_empty(fifo_empty), .occ(occ)
  );

  wtsb_drain #(.CYC_W(CYC_W)) u_drain (
    .clk(clk), .rst_n(rst_n), .have_entry(!fifo_empty),
    .dram_ready(dram_ready), .cycles(dram_wr_cycles),
    .dram_valid(dram_valid), .pop(pop), .in_flight(in_flight)
  );

  assign st_ready  = !full || pop;
  assign push      = st_valid && st_ready;
  assign dram_addr = head.addr;
  assign dram_data = head.data;
  assign dram_be   = head.be;
  assign empty     = fifo_empty && !in_flight;
endmodule

// File: rtl/wtsb_chk.sv
module wtsb_chk #(
  parameter int CYC_W = 8,
  parameter int OCC_W = 3,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             st_valid,
  input logic             st_ready,
  input logic             dram_valid,
  input logic             dram_ready,
  input logic [31:0]      dram_addr,
  input logic [31:0]      dram_data,
  input logic [3:0]       dram_be,
  input logic [CYC_W-1:0] dram_wr_cycles,
  input logic             empty,
  input logic [OCC_W-1:0] occ
);
  logic at_full;
  assign at_full = (occ == OCC_W'(DEPTH));

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    at_full && !(dram_valid && dram_ready) |-> !st_ready); // R3
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    at_full && st_valid && dram_valid && dram_ready |=> at_full); // R4
  AST_WRITE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    dram_valid && dram_ready && dram_wr_cycles > 1 |=> !dram_valid); // R5
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !dram_valid && occ == '0); // R7
  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    dram_valid && !dram_ready |=> dram_valid && $stable(dram_addr)
      && $stable(dram_data) && $stable(dram_be)); // R8
endmodule

bind wt_store_buf wtsb_chk #(.CYC_W(CYC_W), .OCC_W(OCC_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .dram_valid(dram_valid), .dram_ready(dram_ready), .dram_addr(dram_addr),
  .dram_data(dram_data), .dram_be(dram_be), .dram_wr_cycles(dram_wr_cycles),
  .empty(empty), .occ(occ)
);

// File: tb/sim_wt_store_buf.sv
`timescale 1ns/1ps
module sim_wt_store_buf;
  logic        clk = 1'b0;
  logic        rst_n, st_valid, st_ready, dram_valid, dram_ready, empty;
  logic [31:0] st_addr, st_data, dram_addr, dram_data;
  logic [3:0]  st_be, dram_be;
  logic [7:0]  dram_wr_cycles;

  always #2 clk = ~clk;

  wt_store_buf u0 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .dram_wr_cycles(dram_wr_cycles), .dram_valid(dram_valid),
    .dram_ready(dram_ready), .dram_addr(dram_addr), .dram_data(dram_data),
    .dram_be(dram_be), .empty(empty)
  );

  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  logic [67:0] q[$];
  int          gap = 0;

  function automatic bit exp_valid();
    return (q.size() > 0) && (gap == 0);
  endfunction
  function automatic bit exp_ready(bit rdy);
    return (q.size() < 4) || (exp_valid() && rdy);
  endfunction
  function automatic bit exp_empty();
    return (q.size() == 0) && (gap == 0);
  endfunction

  task automatic check(bit ok, string tag, logic [67:0] act, logic [67:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle from a falling edge: drive, sample, advance the model, wait.
  task automatic cycle(bit v, bit r);
    bit pop_e, push_e;
    st_valid   = v;
    st_addr    = $urandom;
    st_data    = $urandom;
    st_be      = 4'($urandom);
    dram_ready = r;
    #1;
    check(dram_valid === exp_valid(), "R5 R6 dram_valid", 68'(dram_valid), 68'(exp_valid()));
    check(st_ready === exp_ready(r),
          (q.size() == 4) ? "R3 R4 st_ready at full" : "R3 st_ready",
          68'(st_ready), 68'(exp_ready(r)));
    check(empty === exp_empty(), "R7 empty", 68'(empty), 68'(exp_empty()));
    if (exp_valid())
      check({dram_addr, dram_data, dram_be} === q[0], "R2 R8 offered entry",
            {dram_addr, dram_data, dram_be}, q[0]);
    pop_e  = exp_valid() && r;
    push_e = v && exp_ready(r);
    if (pop_e) begin
      void'(q.pop_front());
      gap = (dram_wr_cycles == 0) ? 0 : int'(dram_wr_cycles) - 1;
    end else if (gap > 0) begin
      gap--;
    end
    if (push_e) q.push_back({st_addr, st_data, st_be});
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired R1 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; st_valid = 0; dram_ready = 0; dram_wr_cycles = 8'd3;
    st_addr = '0; st_data = '0; st_be = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(empty === 1'b1, "R1 reset empty", 68'(empty), 68'd1);
    check(dram_valid === 1'b0, "R1 reset dram_valid", 68'(dram_valid), 68'd0);
    check(st_ready === 1'b1, "R1 reset st_ready", 68'(st_ready), 68'd1);
    @(negedge clk);

    // Directed: fill with DRAM stalled, offer while full (R3).
    for (int i = 0; i < 7; i++) cycle(1'b1, 1'b0);
    // Directed: swap at full with N=1 (R4), then slow drain with N=4 (R5).
    dram_wr_cycles = 8'd1;
    for (int i = 0; i < 6; i++) cycle(1'b1, 1'b1);
    dram_wr_cycles = 8'd4;
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b1);
    // Directed: N=0 behaves as N=1 (R5).
    dram_wr_cycles = 8'd0;
    for (int i = 0; i < 8; i++) cycle(i < 4, 1'b1);

    // Random traffic with varying write cycle time.
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 49) == 0) dram_wr_cycles = 8'($urandom_range(0, 6));
      cycle($urandom_range(0, 2) != 0, $urandom_range(0, 3) != 0);
    end
    for (int i = 0; i < 40; i++) cycle(1'b0, 1'b1);
    check(empty === 1'b1, "R7 drained empty", 68'(empty), 68'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule